// File: doc/BRIEF.md
# Quad XIP Continuous Read Engine

This block serves 32-bit word reads from an external serial flash over a four-line data bus. A requester offers a 24-bit byte address on a valid/ready request channel. The engine runs one quad-I/O read transfer on the flash pins and returns the word on a valid/ready response channel. It generates the serial clock from the system clock by an even divider and drives chip select. Each data line has its own output enable, so the pad tri-state logic sits outside.

Reads can begin only after an external quad-enable sequence has completed. That is signalled by a plain level input. The engine then runs one priming transfer with no requester involved. This transfer carries the serial read opcode on line 0, then the address and a mode byte whose upper nibble puts the flash into command-less continuous reading. Its data is thrown away. Every later transfer starts straight with the quad address and the mode byte, which saves eight serial clocks per word.

Back-pressure rules: the request channel is ready only while the engine is idle with chip select high. It accepts one request per transfer. The response is held, with its data unchanged, until the response channel is ready. No new request is accepted while a response is still pending.

Top module: `qxip_read_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, all four output enables are 0, and both req_ready_o and rsp_valid_o are 0.
- R2: While setup_done_i has not yet been seen high, no transfer starts and req_ready_o stays 0, whatever the request inputs do. Once priming is done, setup_done_i has no further effect.
- R3: The first transfer after setup_done_i rises is a priming transfer of 28 serial clocks. Its first 8 clocks carry opcode 0xEB on io_o[0], most significant bit first, with io_oe_o = 4'b0001. It produces no response.
- R4: The address phase lasts 8 clocks with io_oe_o = 4'b1111. Over these clocks the engine sends the 24-bit address and then mode byte 0xA0, one nibble per clock, most significant nibble first, with bit 3 of the nibble on io_o[3].
- R5: Every transfer after priming has no opcode phase and lasts exactly 20 serial clocks: 8 address/mode, 4 dummy and 8 data.
- R6: From the first dummy clock until chip select rises, io_oe_o is 0. It is also 0 whenever chip select is high.
- R7: The 8 data nibbles form 4 bytes, each sent high nibble first. The first byte received becomes bits 7:0 of rsp_data_o and the fourth becomes bits 31:24.
- R8: io_i is captured SAMPLE_DLY system clocks after the system clock edge that raises the serial clock (default 1, at most CLK_DIV/2).
- R9: req_ready_o is high only while idle with chip select high, and one request is accepted per transfer. rsp_valid_o stays high with rsp_data_o unchanged until rsp_ready_i is high. While it is pending, req_ready_o is 0 and chip select stays high.
- R10: During a transfer the serial clock has a period of CLK_DIV system clocks, with CLK_DIV/2 high. It idles low while chip select is high. Chip select stays high for at least one system clock between transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setup_done_i | input | 1 | Quad-enable sequence finished (level) |
| req_valid_i | input | 1 | Read request offered |
| req_ready_o | output | 1 | Read request accepted this cycle when valid |
| req_addr_i | input | ADDR_W (24) | Byte address of the word |
| rsp_valid_o | output | 1 | Read data available |
| rsp_ready_i | input | 1 | Requester takes the read data |
| rsp_data_o | output | DATA_W (32) | Read word, first byte in bits 7:0 |
| sclk_o | output | 1 | Flash serial clock |
| csn_o | output | 1 | Flash chip select, active low |
| io_o | output | 4 | Data line output values |
| io_oe_o | output | 4 | Data line output enables |
| io_i | input | 4 | Data line input values |

## Verification
A wrong clock index or phase decode shows up at the flash pins within one transfer. The flash model sees a wrong opcode, a shifted address or mode byte, or an enable still on during a dummy clock, and the transfer length differs from 28 or 20 serial clocks. A faulty capture pipeline or nibble placement corrupts the very next response word. Errors in the handshake or hold logic appear as a changed word or a new transfer within the cycles while the response is held back.

// File: rtl/qxip_pkg.sv
package qxip_pkg;

  localparam int unsigned OPC_CLKS = 8;
  localparam logic [7:0]  OPC_QUAD_READ = 8'hEB;
  localparam logic [7:0]  MODE_CONTINUE = 8'hA0;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_XFER = 2'd1,
    ST_RESP = 2'd2,
    ST_IDLE = 2'd3
  } eng_state_t;

endpackage

// File: rtl/qxip_sclk_gen.sv
module qxip_sclk_gen #(
  parameter int unsigned CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned HALF  = CLK_DIV / 2;
  localparam int unsigned CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             sclk_q;

  assign rise_o = run_i && (cnt_q == CNT_HALF);
  assign fall_o = run_i && (cnt_q == CNT_LAST);
  assign sclk_o = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      if (fall_o) begin
        cnt_q  <= '0;
        sclk_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (rise_o) sclk_q <= 1'b1;
      end
    end
  end

  assert_rise_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o && !fall_o |=> sclk_o);
  assert_fall_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !sclk_o);

endmodule

// File: rtl/qxip_tx_drive.sv
module qxip_tx_drive
  import qxip_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              active_i,
  input  logic              with_opc_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [3:0]        io_o,
  output logic [3:0]        oe_o
);
  localparam int unsigned AM_W    = ADDR_W + 8;
  localparam int unsigned AM_CLKS = AM_W / 4;
  localparam logic [IDX_W-1:0] OPC_END = IDX_W'(OPC_CLKS);
  localparam logic [IDX_W-1:0] AM_END  = IDX_W'(AM_CLKS);

  logic [AM_W-1:0]  am_word;
  logic [AM_W-1:0]  am_shift;
  logic [IDX_W-1:0] am_idx;
  logic [2:0]       opc_bit;

  assign am_word  = {addr_i, MODE_CONTINUE};
  assign am_idx   = with_opc_i ? (idx_i - OPC_END) : idx_i;
  assign am_shift = am_word << {am_idx, 2'b00};
  assign opc_bit  = 3'd7 - idx_i[2:0];

  always_comb begin
    io_o = 4'h0;
    oe_o = 4'h0;
    if (active_i) begin
      if (with_opc_i && (idx_i < OPC_END)) begin
        oe_o    = 4'b0001;
        io_o[0] = OPC_QUAD_READ[opc_bit];
      end else if (am_idx < AM_END) begin
        oe_o = 4'b1111;
        io_o = am_shift[AM_W-1 -: 4];
      end
    end
  end

endmodule

// File: rtl/qxip_rx_gather.sv
module qxip_rx_gather #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SAMPLE_DLY = 1,
  parameter int unsigned NIB_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic [3:0]        io_i,
  output logic [DATA_W-1:0] word_o
);
  logic             take_d;
  logic [NIB_W-1:0] nib_d;
  logic [NIB_W+1:0] pos;
  logic [DATA_W-1:0] word_q;

  generate
    if (SAMPLE_DLY == 0) begin : g_direct
      assign take_d = take_i;
      assign nib_d  = nib_i;
    end else begin : g_pipe
      logic             tp [SAMPLE_DLY];
      logic [NIB_W-1:0] np [SAMPLE_DLY];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < SAMPLE_DLY; i++) begin
            tp[i] <= 1'b0;
            np[i] <= '0;
          end
        end else begin
          tp[0] <= take_i;
          np[0] <= nib_i;
          for (int i = 1; i < SAMPLE_DLY; i++) begin
            tp[i] <= tp[i-1];
            np[i] <= np[i-1];
          end
        end
      end
      assign take_d = tp[SAMPLE_DLY-1];
      assign nib_d  = np[SAMPLE_DLY-1];
    end
  endgenerate

  // byte = nibble/2, high nibble when the nibble index is even
  assign pos = {nib_d[NIB_W-1:1], ~nib_d[0], 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else if (take_d) word_q[pos +: 4] <= io_i;
  end

  assign word_o = word_q;

endmodule

// File: rtl/qxip_read_engine.sv
module qxip_read_engine
  import qxip_pkg::*;
#(
  parameter int unsigned CLK_DIV    = 2,
  parameter int unsigned SAMPLE_DLY = 1,
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DUMMY_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup_done_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              sclk_o,
  output logic              csn_o,
  output logic [3:0]        io_o,
  output logic [3:0]        io_oe_o,
  input  logic [3:0]        io_i
);
  localparam int unsigned AM_CLKS   = (ADDR_W + 8) / 4;
  localparam int unsigned DATA_CLKS = DATA_W / 4;
  localparam int unsigned DS_PLAIN  = AM_CLKS + DUMMY_CLKS;
  localparam int unsigned DS_OPC    = OPC_CLKS + DS_PLAIN;
  localparam int unsigned TOT_OPC   = DS_OPC + DATA_CLKS;
  localparam int unsigned IDX_W     = $clog2(TOT_OPC);
  localparam int unsigned NIB_W     = $clog2(DATA_CLKS);
  localparam logic [IDX_W-1:0] LAST_PLAIN = IDX_W'(DS_PLAIN + DATA_CLKS - 1);
  localparam logic [IDX_W-1:0] LAST_OPC   = IDX_W'(TOT_OPC - 1);
  localparam logic [IDX_W-1:0] DSI_PLAIN  = IDX_W'(DS_PLAIN);
  localparam logic [IDX_W-1:0] DSI_OPC    = IDX_W'(DS_OPC);

  eng_state_t        state_q;
  logic              csn_q;
  logic              with_opc_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              run, rise, fall;
  logic [IDX_W-1:0]  data_start, last_idx, nib_full;
  logic              take;
  logic [NIB_W-1:0]  nib;

  assign run        = (state_q == ST_XFER);
  assign data_start = with_opc_q ? DSI_OPC : DSI_PLAIN;
  assign last_idx   = with_opc_q ? LAST_OPC : LAST_PLAIN;
  assign nib_full   = idx_q - data_start;
  assign nib        = nib_full[NIB_W-1:0];
  assign take       = rise && (idx_q >= data_start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_WAIT;
      csn_q      <= 1'b1;
      with_opc_q <= 1'b0;
      idx_q      <= '0;
      addr_q     <= '0;
    end else begin
      case (state_q)
        ST_WAIT: if (setup_done_i) begin
          state_q    <= ST_XFER;
          csn_q      <= 1'b0;
          with_opc_q <= 1'b1;
          idx_q      <= '0;
          addr_q     <= '0;
        end
        ST_IDLE: if (req_valid_i) begin
          state_q    <= ST_XFER;
          csn_q      <= 1'b0;
          with_opc_q <= 1'b0;
          idx_q      <= '0;
          addr_q     <= req_addr_i;
        end
        ST_XFER: if (fall) begin
          if (idx_q == last_idx) begin
            csn_q   <= 1'b1;
            idx_q   <= '0;
            state_q <= with_opc_q ? ST_IDLE : ST_RESP;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_RESP: if (rsp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_WAIT;
      endcase
    end
  end

  qxip_sclk_gen #(.CLK_DIV(CLK_DIV)) u_sclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .sclk_o (sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  qxip_tx_drive #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_tx (
    .active_i   (run),
    .with_opc_i (with_opc_q),
    .idx_i      (idx_q),
    .addr_i     (addr_q),
    .io_o       (io_o),
    .oe_o       (io_oe_o)
  );

  qxip_rx_gather #(.DATA_W(DATA_W), .SAMPLE_DLY(SAMPLE_DLY), .NIB_W(NIB_W)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (take),
    .nib_i  (nib),
    .io_i   (io_i),
    .word_o (rsp_data_o)
  );

  assign csn_o       = csn_q;
  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_RESP);

  assert_wait_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (csn_o && !req_ready_o && !rsp_valid_o));
  assert_ready_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> csn_o);
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_data_o) && csn_o);
  assert_sclk_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    csn_o |-> !sclk_o);
  assert_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    csn_o |-> (io_oe_o == 4'h0));
  assert_cs_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csn_o) |=> csn_o);

endmodule

// File: tb/qxip_read_engine_test.sv
module qxip_read_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic setup_done = 1'b0;
  logic req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic rsp_ready = 1'b0;
  logic req_ready_o, rsp_valid_o, sclk_o, csn_o;
  logic [31:0] rsp_data_o;
  logic [3:0] io_o, io_oe_o;
  logic [3:0] flash_io = 4'h0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qxip_read_engine #(.CLK_DIV(DIV), .SAMPLE_DLY(1)) uut (
    .clk(clk), .rst_n(rst_n), .setup_done_i(setup_done),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready), .rsp_data_o(rsp_data_o),
    .sclk_o(sclk_o), .csn_o(csn_o), .io_o(io_o), .io_oe_o(io_oe_o), .io_i(flash_io)
  );

  function automatic logic [7:0] fbyte(input logic [23:0] a);
    fbyte = (a[7:0] * 8'd29 + 8'd113) ^ a[15:8] ^ {a[19:16], a[23:20]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  int fk = 0, f_oe_err = 0, xfer_cnt = 0;
  logic fcont = 1'b0;
  logic [7:0] fcmd = '0;
  logic [31:0] fam = '0;
  int rec_clks = 0, rec_oe_err = 0;
  logic [7:0] rec_cmd = '0, rec_mode = '0;
  logic [23:0] rec_addr = '0;
  logic rec_had_cmd = 1'b0;

  always @(negedge csn_o) begin
    fk = 0; fcmd = '0; fam = '0; f_oe_err = 0; xfer_cnt++;
  end

  always @(posedge csn_o) begin
    rec_clks = fk; rec_cmd = fcmd; rec_addr = fam[31:8]; rec_mode = fam[7:0];
    rec_oe_err = f_oe_err; rec_had_cmd = !fcont;
    if (xfer_cnt > 0) fcont = (fam[7:4] == 4'hA);
    flash_io = 4'h0;
  end

  always @(posedge sclk_o) begin : rise_blk
    int base;
    if (csn_o === 1'b0) begin
      base = fcont ? 0 : 8;
      if (fk < base) begin
        if (io_oe_o != 4'b0001) f_oe_err++;
        fcmd = {fcmd[6:0], io_o[0]};
      end else if (fk < base + 8) begin
        if (io_oe_o != 4'hF) f_oe_err++;
        fam = {fam[27:0], io_o};
      end else if (io_oe_o != 4'h0) f_oe_err++;
      fk++;
    end
  end

  always @(negedge sclk_o) begin : fall_blk
    int base, n;
    logic [7:0] b;
    if (csn_o === 1'b0) begin
      base = fcont ? 0 : 8;
      n = fk - (base + 12);
      if (n >= 0 && n < 8) begin
        b = fbyte(24'(fam[31:8] + 24'(n / 2)));
        flash_io = (n % 2 == 1) ? b[3:0] : b[7:4];
      end
    end
  end

  // ---------------- pin shape monitor ----------------
  logic sclk_prev = 1'b0, csn_prev = 1'b1;
  int per_len = 0, hi_len = 0, shape_err = 0, hi_run = 0, rsp_seen = 0;
  bit have_rise = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      per_len++;
      if (sclk_o) hi_len++;
      if (sclk_o && !sclk_prev) begin
        if (have_rise && per_len != DIV) shape_err++;
        have_rise = 1; per_len = 0;
      end
      if (!sclk_o && sclk_prev) begin
        if (hi_len != DIV / 2) shape_err++;
        hi_len = 0;
      end
      if (sclk_o && csn_o) shape_err++;
      if (!csn_o && csn_prev) begin
        if (hi_run < 1) shape_err++;
        have_rise = 0;
      end
      hi_run = csn_o ? hi_run + 1 : 0;
      if (rsp_valid_o) rsp_seen++;
      sclk_prev = sclk_o; csn_prev = csn_o;
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_read(input logic [23:0] a, input int hold);
    logic [31:0] exp, first;
    int guard;
    exp = {fbyte(a + 24'd3), fbyte(a + 24'd2), fbyte(a + 24'd1), fbyte(a)};
    @(negedge clk); req_valid = 1'b1; req_addr = a;
    guard = 0;
    while (!req_ready_o && guard < 1000) begin @(negedge clk); guard++; end
    @(negedge clk); req_valid = 1'b0; req_addr = 24'h5A5A5A;
    chk(!req_ready_o && !csn_o, "R9 single accept", {30'd0, req_ready_o, csn_o}, 32'd0);
    guard = 0;
    while (!rsp_valid_o && guard < 1000) begin @(negedge clk); guard++; end
    chk(rsp_data_o == exp, "R7/R8 read word", rsp_data_o, exp);
    chk(rec_clks == 20, "R5 clocks per read", rec_clks, 20);
    chk(rec_addr == a, "R4 address sent", {8'd0, rec_addr}, {8'd0, a});
    chk(rec_mode == 8'hA0, "R4 mode byte", {24'd0, rec_mode}, 32'hA0);
    chk(rec_oe_err == 0, "R6 enables per phase", rec_oe_err, 0);
    first = rsp_data_o;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid_o && rsp_data_o == first && !req_ready_o && csn_o,
          "R9 response held", rsp_data_o, first);
    end
    rsp_ready = 1'b1;
    @(negedge clk); rsp_ready = 1'b0;
    chk(!rsp_valid_o, "R9 response taken", {31'd0, rsp_valid_o}, 32'd0);
  endtask

  initial begin
    logic [23:0] a;
    int xc;
    repeat (3) @(negedge clk);
    chk(csn_o == 1'b1, "R1 csn reset", csn_o, 1);
    chk(sclk_o == 1'b0, "R1 sclk reset", sclk_o, 0);
    chk(io_oe_o == 4'h0, "R1 oe reset", io_oe_o, 0);
    chk(!req_ready_o && !rsp_valid_o, "R1 handshake reset", {req_ready_o, rsp_valid_o}, 0);
    rst_n = 1'b1;
    req_valid = 1'b1; req_addr = 24'h123456;
    xc = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!csn_o || req_ready_o) xc++;
    end
    chk(xc == 0, "R2 quiet before setup", xc, 0);
    chk(xfer_cnt == 0, "R2 no transfer before setup", xfer_cnt, 0);
    req_valid = 1'b0;
    setup_done = 1'b1;
    xc = 0;
    while (!req_ready_o && xc < 1000) begin @(negedge clk); xc++; end
    setup_done = 1'b0;
    chk(rec_clks == 28, "R3 priming length", rec_clks, 28);
    chk(rec_had_cmd && rec_cmd == 8'hEB, "R3 priming opcode", {24'd0, rec_cmd}, 32'hEB);
    chk(rec_mode == 8'hA0, "R4 priming mode", {24'd0, rec_mode}, 32'hA0);
    chk(rec_oe_err == 0, "R3/R6 priming enables", rec_oe_err, 0);
    chk(rsp_seen == 0, "R3 priming discarded", rsp_seen, 0);
    chk(xfer_cnt == 1, "R3 single priming", xfer_cnt, 1);

    do_read(24'h000000, 0);
    do_read(24'hFFFFFF, 1);
    do_read(24'hFFFFFE, 2);
    for (int b = 0; b < 24; b++) do_read(24'd1 << b, b % 4);
    a = 24'h3C1F07;
    for (int i = 0; i < 20; i++) begin
      a = 24'(a * 24'd1103515 + 24'd12345);
      do_read(a, i % 3);
    end

    xc = xfer_cnt;
    setup_done = 1'b1;
    repeat (30) @(negedge clk);
    setup_done = 1'b0;
    chk(xfer_cnt == xc && csn_o, "R2 setup ignored after priming", xfer_cnt, xc);
    do_read(24'hABCDEF, 1);
    chk(shape_err == 0, "R10 sclk and cs shape", shape_err, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule